// File: doc/BRIEF.md
# Link Packet Transaction Assembler

This block sits above a link layer that delivers one fixed-size DWORD packet per cycle. Each packet carries a valid strobe, a first-packet marker, a last-packet marker, a type field and a data-error flag. The block groups packets into transactions of any length, captures the transaction type from the opening packet, and reports each finished transaction as either a commit or an abort.

The block keeps one bit of context: inside or outside a transaction. Outside a transaction only a first-packet marker can open one, and any other traffic is dropped as garbage. Inside a transaction an error flag on any packet marks the result as an abort. A second first-packet marker inside an open transaction closes it as an abort and does not start a new one. The type of the closed transaction stays on `txn_type` until the next opening. A transaction's result is always reported one cycle after its end pulse. Payload is not stored or checked.

Top module: `pkt_txn_assembler`

## Requirements
- R1: While `rst` is high at a clock edge, all pulse outputs and `txn_active` are 0 after that edge, and `txn_type` is 0.
- R2: A valid packet with `pkt_sop`=1 and `pkt_eop`=0 that arrives outside a transaction raises `start_pulse` for one cycle after its edge. From that cycle `txn_active` is 1 and `txn_type` equals the packet's `pkt_type`.
- R3: A valid packet with `pkt_sop`=0 that arrives outside a transaction is ignored. After its edge, `start_pulse`, `end_pulse` and `txn_active` stay 0, and `txn_type` keeps its value.
- R4: A valid packet with `pkt_eop`=1 and `pkt_sop`=0 that arrives inside a transaction raises `end_pulse` for one cycle after its edge. In that cycle `txn_active` returns to 0.
- R5: Exactly one cycle after each `end_pulse` cycle, exactly one of `commit_pulse` or `abort_pulse` is high for one cycle.
- R6: The result is a commit when no packet of the transaction had `pkt_err`=1. It is an abort when the error flag was set on the first, a middle or the last packet.
- R7: A valid packet with both `pkt_sop` and `pkt_eop` set that arrives outside a transaction is a single-packet transaction. `start_pulse` and `end_pulse` are high together in the next cycle, `txn_type` loads its type, `txn_active` stays 0, and the result depends on that packet's error flag.
- R8: A valid packet with `pkt_sop`=1 that arrives inside a transaction closes the current transaction. After its edge, `end_pulse` is 1, `start_pulse` is 0, `txn_active` is 0 and `txn_type` is unchanged, and the result one cycle later is an abort.
- R9: `commit_pulse` and `abort_pulse` are never high together, and neither is high unless `end_pulse` was high in the previous cycle.
- R10: While `pkt_valid` is 0, the markers, type and error inputs have no effect on any output.
- R11: A new transaction may open on the packet directly after a closing packet. Its `start_pulse` coincides with the earlier transaction's result pulse, and the two do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_sop | input | 1 | Packet is the first of a transaction |
| pkt_eop | input | 1 | Packet is the last of a transaction |
| pkt_type | input | TYPE_W | Transaction type, meaningful on the first packet |
| pkt_err | input | 1 | Data error detected on this packet |
| txn_active | output | 1 | A multi-packet transaction is open |
| txn_type | output | TYPE_W | Type latched from the last opening packet |
| start_pulse | output | 1 | One-cycle pulse: a transaction opened |
| end_pulse | output | 1 | One-cycle pulse: a transaction closed |
| commit_pulse | output | 1 | One-cycle pulse: closed transaction committed |
| abort_pulse | output | 1 | One-cycle pulse: closed transaction aborted |

## Verification
The stimulus runs through the following cases:
- Garbage bursts outside a transaction, with varied types and error flags. These show whether stray traffic can open a transaction or change the latched type.
- Clean three-packet transactions next to transactions with the error flag on the first, a middle or the last packet. These separate correct error accumulation from logic that only samples one position.
- Single-packet transactions, restarts inside an open transaction, and back-to-back transactions with no idle cycle. These cover the cases where start, end and result pulses overlap.
- Cycles with `pkt_valid` low but markers and type set. These show that the block ignores input without a valid strobe.

// File: rtl/pta_pkg.sv
package pta_pkg;

    // Meaning of one input cycle, given the current inside/outside context.
    typedef enum logic [2:0] {
        EV_IDLE    = 3'd0,  // no valid packet
        EV_DROP    = 3'd1,  // valid packet outside a transaction, not an opener
        EV_OPEN    = 3'd2,  // opener of a multi-packet transaction
        EV_SINGLE  = 3'd3,  // opener that is also the closer
        EV_BODY    = 3'd4,  // middle packet of an open transaction
        EV_CLOSE   = 3'd5,  // closing packet of an open transaction
        EV_RESTART = 3'd6   // opener seen inside a transaction: forced abort
    } pta_event_e;

endpackage

// File: rtl/pta_classify.sv
module pta_classify
    import pta_pkg::*;
(
    input  logic       pkt_valid,
    input  logic       pkt_sop,
    input  logic       pkt_eop,
    input  logic       in_txn,
    output pta_event_e ev
);

    always_comb begin
        ev = EV_IDLE;
        if (pkt_valid) begin
            if (!in_txn) begin
                if (!pkt_sop)     ev = EV_DROP;
                else if (pkt_eop) ev = EV_SINGLE;
                else              ev = EV_OPEN;
            end else begin
                if (pkt_sop)      ev = EV_RESTART;
                else if (pkt_eop) ev = EV_CLOSE;
                else              ev = EV_BODY;
            end
        end
    end

endmodule

// File: rtl/pta_ctrl.sv
module pta_ctrl
    import pta_pkg::*;
#(
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  pta_event_e        ev,
    input  logic [TYPE_W-1:0] pkt_type,
    input  logic              pkt_err,
    output logic              in_txn,
    output logic [TYPE_W-1:0] cur_type,
    output logic              start_pulse,
    output logic              close_pulse,
    output logic              close_abort
);

    typedef struct packed {
        logic              in_txn;
        logic              err_seen;
        logic [TYPE_W-1:0] ttype;
        logic              start;
        logic              close;
        logic              close_abort;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.start       = 1'b0;
        st_d.close       = 1'b0;
        st_d.close_abort = 1'b0;
        unique case (ev)
            EV_OPEN: begin
                st_d.in_txn   = 1'b1;
                st_d.err_seen = pkt_err;
                st_d.ttype    = pkt_type;
                st_d.start    = 1'b1;
            end
            EV_SINGLE: begin
                st_d.in_txn      = 1'b0;
                st_d.err_seen    = 1'b0;
                st_d.ttype       = pkt_type;
                st_d.start       = 1'b1;
                st_d.close       = 1'b1;
                st_d.close_abort = pkt_err;
            end
            EV_BODY: begin
                st_d.err_seen = st_q.err_seen | pkt_err;
            end
            EV_CLOSE: begin
                st_d.in_txn      = 1'b0;
                st_d.err_seen    = 1'b0;
                st_d.close       = 1'b1;
                st_d.close_abort = st_q.err_seen | pkt_err;
            end
            EV_RESTART: begin
                st_d.in_txn      = 1'b0;
                st_d.err_seen    = 1'b0;
                st_d.close       = 1'b1;
                st_d.close_abort = 1'b1;
            end
            default: begin
                // EV_IDLE and EV_DROP leave the context untouched
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_txn      = st_q.in_txn;
    assign cur_type    = st_q.ttype;
    assign start_pulse = st_q.start;
    assign close_pulse = st_q.close;
    assign close_abort = st_q.close_abort;

endmodule

// File: rtl/pta_result.sv
module pta_result (
    input  logic clk,
    input  logic rst,
    input  logic close_pulse,
    input  logic close_abort,
    output logic commit_pulse,
    output logic abort_pulse
);

    typedef struct packed {
        logic commit;
        logic abort;
    } res_state_t;

    res_state_t rs_d, rs_q;

    always_comb begin
        rs_d.commit = close_pulse & ~close_abort;
        rs_d.abort  = close_pulse &  close_abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign commit_pulse = rs_q.commit;
    assign abort_pulse  = rs_q.abort;

endmodule

// File: rtl/pkt_txn_assembler.sv
module pkt_txn_assembler
    import pta_pkg::*;
#(
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic              pkt_sop,
    input  logic              pkt_eop,
    input  logic [TYPE_W-1:0] pkt_type,
    input  logic              pkt_err,
    output logic              txn_active,
    output logic [TYPE_W-1:0] txn_type,
    output logic              start_pulse,
    output logic              end_pulse,
    output logic              commit_pulse,
    output logic              abort_pulse
);

    pta_event_e ev;
    logic       in_txn;
    logic       close_pulse;
    logic       close_abort;

    pta_classify u_classify (
        .pkt_valid (pkt_valid),
        .pkt_sop   (pkt_sop),
        .pkt_eop   (pkt_eop),
        .in_txn    (in_txn),
        .ev        (ev)
    );

    pta_ctrl #(.TYPE_W(TYPE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .pkt_type    (pkt_type),
        .pkt_err     (pkt_err),
        .in_txn      (in_txn),
        .cur_type    (txn_type),
        .start_pulse (start_pulse),
        .close_pulse (close_pulse),
        .close_abort (close_abort)
    );

    pta_result u_result (
        .clk          (clk),
        .rst          (rst),
        .close_pulse  (close_pulse),
        .close_abort  (close_abort),
        .commit_pulse (commit_pulse),
        .abort_pulse  (abort_pulse)
    );

    assign txn_active = in_txn;
    assign end_pulse  = close_pulse;

endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
    parameter int TYPE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pkt_valid,
    input logic              pkt_sop,
    input logic              pkt_eop,
    input logic [TYPE_W-1:0] pkt_type,
    input logic              pkt_err,
    input logic              txn_active,
    input logic [TYPE_W-1:0] txn_type,
    input logic              start_pulse,
    input logic              end_pulse,
    input logic              commit_pulse,
    input logic              abort_pulse
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !txn_active && !start_pulse && !end_pulse && !commit_pulse && !abort_pulse);

    a_r2_open_loads_type: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_sop && !pkt_eop && !txn_active)
            |=> start_pulse && txn_active && txn_type == $past(pkt_type));

    a_r3_garbage_ignored: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_sop && !txn_active)
            |=> !start_pulse && !end_pulse && !txn_active && $stable(txn_type));

    a_r5_result_follows_end: assert property (@(posedge clk) disable iff (rst)
        end_pulse |=> (commit_pulse || abort_pulse));

    a_r6_error_close_aborts: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && txn_active && !pkt_sop && pkt_eop && pkt_err)
            |=> end_pulse ##1 abort_pulse);

    a_r8_restart_aborts: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && txn_active && pkt_sop)
            |=> end_pulse && !start_pulse && !txn_active && $stable(txn_type) ##1 abort_pulse);

    a_r9_result_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit_pulse, abort_pulse}));

    a_r9_result_needs_end: assert property (@(posedge clk) disable iff (rst)
        (commit_pulse || abort_pulse) |-> $past(end_pulse));

    a_r10_invalid_no_open: assert property (@(posedge clk) disable iff (rst)
        (!pkt_valid && !txn_active) |=> !start_pulse && !end_pulse && !txn_active);

endmodule

bind pkt_txn_assembler pta_checker #(.TYPE_W(TYPE_W)) u_pta_checker (
    .clk          (clk),
    .rst          (rst),
    .pkt_valid    (pkt_valid),
    .pkt_sop      (pkt_sop),
    .pkt_eop      (pkt_eop),
    .pkt_type     (pkt_type),
    .pkt_err      (pkt_err),
    .txn_active   (txn_active),
    .txn_type     (txn_type),
    .start_pulse  (start_pulse),
    .end_pulse    (end_pulse),
    .commit_pulse (commit_pulse),
    .abort_pulse  (abort_pulse)
);

// File: tb/pkt_txn_assembler_bench.sv
module pkt_txn_assembler_bench;

    localparam int TYPE_W = 4;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pkt_valid = 1'b0;
    logic              pkt_sop = 1'b0;
    logic              pkt_eop = 1'b0;
    logic [TYPE_W-1:0] pkt_type = '0;
    logic              pkt_err = 1'b0;
    logic              txn_active;
    logic [TYPE_W-1:0] txn_type;
    logic              start_pulse;
    logic              end_pulse;
    logic              commit_pulse;
    logic              abort_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_inside, m_errs, m_type;
    int m_start, m_end, m_commit, m_abort;
    int pending[$];   // result of a closed transaction: 1 = abort, 0 = commit

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_txn_assembler #(.TYPE_W(TYPE_W)) u_pkt_txn_assembler (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
        .pkt_eop(pkt_eop), .pkt_type(pkt_type), .pkt_err(pkt_err),
        .txn_active(txn_active), .txn_type(txn_type), .start_pulse(start_pulse),
        .end_pulse(end_pulse), .commit_pulse(commit_pulse), .abort_pulse(abort_pulse)
    );

    task automatic check(string req, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        check(req, "txn_active",   int'(txn_active),   m_inside);
        check(req, "txn_type",     int'(txn_type),     m_type);
        check(req, "start_pulse",  int'(start_pulse),  m_start);
        check(req, "end_pulse",    int'(end_pulse),    m_end);
        check(req, "commit_pulse", int'(commit_pulse), m_commit);
        check(req, "abort_pulse",  int'(abort_pulse),  m_abort);
    endtask

    // advance the reference by one edge using the inputs present at it
    task automatic model_edge(bit v, bit s, bit e, int t, bit er);
        m_commit = 0; m_abort = 0; m_start = 0; m_end = 0;
        if (pending.size() > 0) begin
            if (pending.pop_front() != 0) m_abort = 1; else m_commit = 1;
        end
        if (v) begin
            if (m_inside == 1) begin
                if (s) begin
                    m_end = 1; m_inside = 0; pending.push_back(1);
                end else begin
                    if (er) m_errs++;
                    if (e) begin
                        m_end = 1; m_inside = 0;
                        pending.push_back(m_errs > 0 ? 1 : 0);
                    end
                end
            end else if (s) begin
                m_start = 1; m_type = t; m_errs = er ? 1 : 0;
                if (e) begin
                    m_end = 1; pending.push_back(m_errs > 0 ? 1 : 0);
                end else begin
                    m_inside = 1;
                end
            end
        end
    endtask

    task automatic step(string req, bit v, bit s, bit e, int t, bit er);
        pkt_valid = v; pkt_sop = s; pkt_eop = e;
        pkt_type = TYPE_W'(t); pkt_err = er;
        @(posedge clk);
        model_edge(v, s, e, t, er);
        #(CLK_PERIOD/4);
        compare(req);
        @(negedge clk);
    endtask

    task automatic idle(string req, int n);
        for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_inside = 0; m_errs = 0; m_type = 0;
        m_start = 0; m_end = 0; m_commit = 0; m_abort = 0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        compare("R1");
        rst = 1'b0;

        // R3: garbage outside a transaction, varied type and error
        step("R3", 1, 0, 0, 7, 0);
        step("R3", 1, 0, 1, 9, 1);
        step("R3", 1, 0, 0, 3, 1);
        // R10: markers without valid
        step("R10", 0, 1, 0, 5, 0);
        step("R10", 0, 1, 1, 6, 1);

        // R2 R4 R5 R6: clean three-packet transaction -> commit
        step("R2", 1, 1, 0, 5, 0);
        step("R10", 0, 1, 1, 2, 1);
        step("R6", 1, 0, 0, 1, 0);
        step("R4", 1, 0, 1, 1, 0);
        step("R5", 0, 0, 0, 0, 0);
        idle("R5", 1);

        // R6: error in middle, first, last
        step("R2", 1, 1, 0, 10, 0);
        step("R6", 1, 0, 0, 0, 1);
        step("R4", 1, 0, 1, 0, 0);
        idle("R6", 2);
        step("R2", 1, 1, 0, 11, 1);
        step("R6", 1, 0, 0, 0, 0);
        step("R4", 1, 0, 1, 0, 0);
        idle("R6", 2);
        step("R2", 1, 1, 0, 12, 0);
        step("R6", 1, 0, 0, 0, 0);
        step("R4", 1, 0, 1, 0, 1);
        idle("R6", 2);

        // R3 after a transaction: type must hold
        step("R3", 1, 0, 1, 4, 0);
        idle("R3", 1);

        // R7: single-packet transactions
        step("R7", 1, 1, 1, 13, 0);
        idle("R7", 2);
        step("R7", 1, 1, 1, 14, 1);
        idle("R7", 2);

        // R8: restart inside a transaction
        step("R2", 1, 1, 0, 3, 0);
        step("R6", 1, 0, 0, 0, 0);
        step("R8", 1, 1, 0, 8, 0);
        step("R8", 1, 0, 0, 8, 0);
        idle("R8", 1);

        // R11: back-to-back transactions
        step("R2", 1, 1, 0, 2, 0);
        step("R4", 1, 0, 1, 0, 1);
        step("R11", 1, 1, 0, 6, 0);
        step("R11", 1, 0, 1, 0, 0);
        step("R11", 1, 1, 1, 15, 0);
        step("R11", 1, 1, 0, 9, 0);
        step("R9", 1, 0, 1, 0, 0);
        idle("R9", 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule